// File: doc/BRIEF.md
# Mode-Controlled System Clock Strobe Generator

This block turns one fast reference clock into four clock-enable strobes: one for the processor, one for the compute engine, one shared by the ADC and its decimation filter, and one for a debug emulator. Each strobe is high for exactly one reference cycle. Downstream logic stays on the reference clock and advances only when its strobe is high, so no gated clock trees are needed. All frequencies are ratios of the reference clock. With a 40 MHz reference, a divide-by-8 strobe stands for 5 MHz.

A two-bit frequency mode selects the master divider. Mode 00 (and the unused code 11) divides the reference by 4. Mode 01 divides it by 3, which moves every domain up by one third. Mode 10 keeps the divide-by-4 master and allows the compute engine to run at twice its normal rate. A three-bit field divides the master strobe further to give the processor strobe. A sleep flag forces the mode to 00. A brownout flag removes one pulse out of every eight from each strobe stream, which gives 7/8 of the normal rate. New divider and mode values are taken only at the terminal count of the divider they affect, so a pulse is never short.

Top module: `sysclk_strobe_gen`

## Requirements
- R1: In mode 00 the master strobe period is 4 reference cycles, and `proc_en` pulses once every 4·2^(d+2) reference cycles, where d is `proc_div`.
- R2: `emu_en` pulses at twice the rate of `proc_en`, and every `proc_en` pulse coincides with an `emu_en` pulse when brownout is low.
- R3: While `emu_off` is 1, `emu_en` stays at 0.
- R4: In mode 10 (`fmode` = 2'b10), `ce_en` has a period of 4 reference cycles when `ce_fast` is 1 and 8 when it is 0, and `smp_en` has a period of 8 either way.
- R5: In mode 01 (`fmode` = 2'b01) the master period is 3 reference cycles, `ce_en` and `smp_en` have a period of 6, and `proc_en` has a period of 3·2^(d+2).
- R6: While `sleep` is 1, all strobes run exactly as in mode 00, whatever `fmode` and `ce_fast` hold.
- R7: While `brownout` is 1, each strobe stream, counted from the assertion of brownout, drops its 8th, 16th, 24th, … pulse.
- R8: `proc_div` values of 7 and above act as 6.
- R9: A new `proc_div` takes effect only after the processor period in progress finishes at its old length. A new mode is taken only at a master terminal count.
- R10: While `rst` is 1 all strobes are 0. After release in mode 00 with d = 0, the first `ce_en` is seen after the 7th rising edge and the first `proc_en` after the 15th.
- R11: Mode 11 behaves exactly like mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| fmode | input | 2 | Frequency mode (00 normal, 01 one-third faster, 10 compute-engine speed option, 11 as 00) |
| proc_div | input | 3 | Processor divider exponent d, period = master·2^(d+2) |
| ce_fast | input | 1 | Compute-engine double rate in mode 10 |
| emu_off | input | 1 | Suppresses the emulator strobe |
| sleep | input | 1 | Forces mode 00 |
| brownout | input | 1 | Scales all strobe rates by 7/8 |
| proc_en | output | 1 | Processor clock enable |
| ce_en | output | 1 | Compute-engine clock enable |
| smp_en | output | 1 | ADC and filter clock enable |
| emu_en | output | 1 | Emulator clock enable |

## Verification
The checker evaluates the relations that hold in every cycle. These are: the processor and compute-engine strobes line up with the master strobe, the emulator strobe is silent while disabled and pairs with each processor pulse, sleep pulls the active mode to 00 at the master boundary, the active mode moves only at a terminal count, and the active divider never exceeds 6. Rates cannot be seen in a single cycle, so the bench's scenarios establish them by counting pulses over a window that is a common multiple of all periods. The scenarios cover every mode, the sleep override, the divider clamp and the 7/8 brownout thinning. Directed runs measure the first pulses after reset and the full-length old period when the divider changes.

// File: rtl/sysclk_strobe_gen.sv
module sysclk_strobe_gen #(
  parameter int DIVW      = 3,
  parameter int DIV_MAX   = 6,
  parameter int NORM_MDIV = 4,
  parameter int FAST_MDIV = 3,
  parameter int BO_SLOTS  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      fmode,
  input  logic [DIVW-1:0] proc_div,
  input  logic            ce_fast,
  input  logic            emu_off,
  input  logic            sleep,
  input  logic            brownout,
  output logic            proc_en,
  output logic            ce_en,
  output logic            smp_en,
  output logic            emu_en
);
  localparam int MMAX = (NORM_MDIV > FAST_MDIV) ? NORM_MDIV : FAST_MDIV;
  localparam int MCW  = (MMAX > 1) ? $clog2(MMAX) : 1;
  localparam int PCW  = DIV_MAX + 2;
  localparam int BOW  = (BO_SLOTS > 1) ? $clog2(BO_SLOTS) : 1;
  localparam int NOUT = 4;

  logic [1:0]      md_req, md_act;
  logic [MCW-1:0]  mcnt, mlim;
  logic            mck_en;
  logic [DIVW-1:0] div_req, div_act;
  logic [PCW-1:0]  pcnt, plim;
  logic            p_term;
  logic            ph, fast_on;
  logic [NOUT-1:0] raw, gate;

  assign md_req  = sleep ? 2'b00 : fmode;
  assign mlim    = (md_act == 2'b01) ? MCW'(FAST_MDIV - 1) : MCW'(NORM_MDIV - 1);
  assign mck_en  = (mcnt == mlim);

  always_ff @(posedge clk) begin
    if (rst) begin
      mcnt   <= '0;
      md_act <= 2'b00;
    end else if (mck_en) begin
      mcnt   <= '0;
      md_act <= md_req;
    end else begin
      mcnt   <= mcnt + 1'b1;
    end
  end

  assign div_req = (proc_div > DIVW'(DIV_MAX)) ? DIVW'(DIV_MAX) : proc_div;
  assign plim    = PCW'((1 << (int'(div_act) + 2)) - 1);
  assign p_term  = mck_en && (pcnt == plim);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt    <= '0;
      div_act <= '0;
    end else if (p_term) begin
      pcnt    <= '0;
      div_act <= div_req;
    end else if (mck_en) begin
      pcnt    <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= 1'b0;
      fast_on <= 1'b0;
    end else if (mck_en) begin
      ph <= ~ph;
      if (ph) fast_on <= ce_fast && (md_req == 2'b10);
    end
  end

  assign raw[0] = p_term;
  assign raw[1] = mck_en && (ph || fast_on);
  assign raw[2] = mck_en && ph;
  assign raw[3] = mck_en && !emu_off && ((pcnt == plim) || (pcnt == (plim >> 1)));

  for (genvar g = 0; g < NOUT; g++) begin : g_thin
    logic [BOW-1:0] bcnt;
    assign gate[g] = brownout && (bcnt == BOW'(BO_SLOTS - 1));
    always_ff @(posedge clk) begin
      if (rst || !brownout) bcnt <= '0;
      else if (raw[g])      bcnt <= gate[g] ? '0 : bcnt + 1'b1;
    end
  end

  assign {emu_en, smp_en, ce_en, proc_en} = raw & ~gate;
endmodule

module sysclk_strobe_gen_chk #(
  parameter int DIVW    = 3,
  parameter int DIV_MAX = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            mck_en,
  input logic [1:0]      md_act,
  input logic [DIVW-1:0] div_act,
  input logic            proc_en,
  input logic            ce_en,
  input logic            smp_en,
  input logic            emu_en,
  input logic            emu_off,
  input logic            sleep,
  input logic            brownout
);
  AST_PROC_ON_MASTER: assert property (@(posedge clk) disable iff (rst) proc_en |-> mck_en); // R1
  AST_EMU_PAIRS_PROC: assert property (@(posedge clk) disable iff (rst) (proc_en && !emu_off && !brownout) |-> emu_en); // R2
  AST_EMU_MUTED: assert property (@(posedge clk) disable iff (rst) emu_off |-> !emu_en); // R3
  AST_CE_ON_MASTER: assert property (@(posedge clk) disable iff (rst) ce_en |-> mck_en); // R4
  AST_SMP_WITH_CE: assert property (@(posedge clk) disable iff (rst) (smp_en && !brownout) |-> ce_en); // R5
  AST_SLEEP_FORCES_LOW: assert property (@(posedge clk) disable iff (rst) (sleep && mck_en) |=> (md_act == 2'b00)); // R6
  AST_DIV_CLAMPED: assert property (@(posedge clk) disable iff (rst) div_act <= DIVW'(DIV_MAX)); // R8
  AST_MODE_AT_TERMINAL: assert property (@(posedge clk) disable iff (rst) !mck_en |=> $stable(md_act)); // R9
endmodule

bind sysclk_strobe_gen sysclk_strobe_gen_chk #(.DIVW(DIVW), .DIV_MAX(DIV_MAX)) u_chk (
  .clk(clk), .rst(rst), .mck_en(mck_en), .md_act(md_act), .div_act(div_act),
  .proc_en(proc_en), .ce_en(ce_en), .smp_en(smp_en), .emu_en(emu_en),
  .emu_off(emu_off), .sleep(sleep), .brownout(brownout)
);

// File: tb/sysclk_strobe_gen_tb.sv
module sysclk_strobe_gen_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] fmode = 2'b00;
  logic [2:0] proc_div = 3'd0;
  logic ce_fast = 1'b0, emu_off = 1'b0, sleep = 1'b0, brownout = 1'b0;
  logic proc_en, ce_en, smp_en, emu_en;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  sysclk_strobe_gen u_dut (
    .clk(clk), .rst(rst), .fmode(fmode), .proc_div(proc_div), .ce_fast(ce_fast),
    .emu_off(emu_off), .sleep(sleep), .brownout(brownout),
    .proc_en(proc_en), .ce_en(ce_en), .smp_en(smp_en), .emu_en(emu_en)
  );

  localparam int WIN = 3072;
  localparam int NV  = 14;
  // {req, mode, div, fast, emu_off, sleep, brownout, ce, smp, proc, emu}
  localparam logic [56:0] VT [NV] = '{
    {4'd1,  2'b00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd384, 11'd384, 11'd192, 11'd384}, // R1
    {4'd1,  2'b00, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 11'd384, 11'd384, 11'd24,  11'd48},  // R1 R2
    {4'd2,  2'b00, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 11'd384, 11'd384, 11'd3,   11'd6},   // R2
    {4'd8,  2'b00, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 11'd384, 11'd384, 11'd3,   11'd6},   // R8
    {4'd4,  2'b10, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd384, 11'd384, 11'd96,  11'd192}, // R4
    {4'd4,  2'b10, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 11'd768, 11'd384, 11'd96,  11'd192}, // R4
    {4'd5,  2'b01, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd512, 11'd512, 11'd256, 11'd512}, // R5
    {4'd3,  2'b01, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 11'd512, 11'd512, 11'd64,  11'd0},   // R3
    {4'd6,  2'b01, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 11'd384, 11'd384, 11'd192, 11'd384}, // R6
    {4'd6,  2'b10, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 11'd384, 11'd384, 11'd192, 11'd384}, // R6
    {4'd7,  2'b00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 11'd336, 11'd336, 11'd168, 11'd336}, // R7
    {4'd7,  2'b01, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 11'd448, 11'd448, 11'd56,  11'd112}, // R7
    {4'd11, 2'b11, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd384, 11'd384, 11'd192, 11'd384}, // R11
    {4'd7,  2'b10, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 11'd672, 11'd336, 11'd11,  11'd21}   // R7
  };

  task automatic check(input int req, input string what, input bit ok, input string got, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %s expected %s", req, what, got, exp);
    end
  endtask

  task automatic measure(output int c_ce, output int c_smp, output int c_pr, output int c_em);
    c_ce = 0; c_smp = 0; c_pr = 0; c_em = 0;
    for (int i = 0; i < WIN; i++) begin
      c_ce += int'(ce_en); c_smp += int'(smp_en); c_pr += int'(proc_en); c_em += int'(emu_en);
      @(negedge clk); #1;
    end
  endtask

  task automatic wait_proc(output int t);
    t = 0;
    do begin @(negedge clk); #1; t++; end while (!proc_en && t < 5000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(10, "watchdog", 1'b0, "timeout", "finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int fce, fpr, c_ce, c_smp, c_pr, c_em, t;
    bit quiet;
    // R10: reset state
    quiet = 1'b1;
    repeat (6) begin
      @(negedge clk); #1;
      if (proc_en || ce_en || smp_en || emu_en) quiet = 1'b0;
    end
    check(10, "strobes in reset", quiet, $sformatf("%b", {proc_en, ce_en, smp_en, emu_en}), "0000");
    // R10: first pulses after release
    @(negedge clk); rst = 1'b0;
    fce = 0; fpr = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk); #1;
      if (ce_en && fce == 0) fce = k;
      if (proc_en && fpr == 0) fpr = k;
    end
    check(10, "first ce_en edge", fce == 7, $sformatf("%0d", fce), "7");
    check(10, "first proc_en edge", fpr == 15, $sformatf("%0d", fpr), "15");

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      fmode = VT[v][52:51]; proc_div = VT[v][50:48]; ce_fast = VT[v][47];
      emu_off = VT[v][46]; sleep = VT[v][45]; brownout = 1'b0;
      repeat (WIN) @(negedge clk);
      brownout = VT[v][44];
      #1;
      measure(c_ce, c_smp, c_pr, c_em);
      check(int'(VT[v][56:53]), $sformatf("vector %0d counts ce/smp/proc/emu", v),
            c_ce == int'(VT[v][43:33]) && c_smp == int'(VT[v][32:22]) &&
            c_pr == int'(VT[v][21:11]) && c_em == int'(VT[v][10:0]),
            $sformatf("%0d/%0d/%0d/%0d", c_ce, c_smp, c_pr, c_em),
            $sformatf("%0d/%0d/%0d/%0d", VT[v][43:33], VT[v][32:22], VT[v][21:11], VT[v][10:0]));
      brownout = 1'b0;
    end

    // R9: divider change completes the old period first
    @(negedge clk);
    fmode = 2'b00; proc_div = 3'd6; ce_fast = 1'b0; emu_off = 1'b0; sleep = 1'b0; brownout = 1'b0;
    repeat (WIN) @(negedge clk);
    #1;
    wait_proc(t);
    t = 0;
    do begin
      @(negedge clk); #1; t++;
      if (t == 300) proc_div = 3'd0;
    end while (!proc_en && t < 5000);
    check(9, "period spanning divider change", t == 1024, $sformatf("%0d", t), "1024");
    wait_proc(t);
    check(9, "first period with new divider", t == 16, $sformatf("%0d", t), "16");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule